// File: doc/BRIEF.md
# Video Controller Register Interface with Window Steering

This block is the processor-facing register front end of a display controller in an 8-bit system. The CPU sees two windows through it. The first is a 128-byte register window. In that window the CPU can read back the current raster line, read and write a control byte, set a vertical-blank interrupt mask, and write a key register. A two-byte key sequence written to the key register switches the controller from its legacy mode to its extended mode.

The second window is 1 KB of I/O space. Bit 0 of the control byte decides where an access to it goes. When the bit is set, the access goes to a color RAM port. When it is clear, the access goes out as a chip-select on the peripheral bus. At each vertical blank the block can raise an interrupt. The interrupt stays raised until the CPU acknowledges it. Reads and writes are single-cycle. Read data is combinational from the address. Writes take effect at the clock edge.

Top module: `vid_regif`

## Requirements
- R1: After reset the control byte and interrupt mask read as 0x00, the mode output `ext_mode` is 0 (legacy), the key sequencer is unarmed, and `irq` is 0.
- R2: A read of register offset 0x12 returns raster bits 7..0. A read of offset 0x11 returns the raster bits above bit 7, right-aligned and zero-padded.
- R3: Offset 0x30 is an 8-bit control byte. A write stores all 8 bits. A read returns the stored value. The control byte does not change on any other write.
- R4: A write to offset 0x1A keeps only data bits 3..0 as the interrupt mask. A read of 0x1A returns the mask with bits 7..4 as zero.
- R5: A write of 0xA5 to offset 0x2F arms the key sequencer. If the next write to 0x2F is 0x96, `ext_mode` becomes 1 after that write's clock edge.
- R6: Every write to 0x2F that does not complete the sequence sets `ext_mode` to 0. A write of 0xA5 re-arms the sequencer. Any other value disarms it.
- R7: When control bit 0 is 1, an access to the I/O window asserts `cram_en`. It passes the 10-bit window offset on `cram_addr` and the write data on `cram_wdata`. `cram_we` follows the write strobe. The read returns `cram_rdata`. `per_cs` stays 0.
- R8: When control bit 0 is 0, an access to the I/O window asserts `per_cs`, with `per_we` following the write strobe. The read returns `per_rdata`. `cram_en` and `cram_we` stay 0.
- R9: A `vblank` pulse sets `irq` at the next clock edge only if mask bit 0 is 1. Otherwise `irq` stays unchanged.
- R10: `irq` stays at 1 until a cycle with `irq_ack` high, and it clears at that clock edge. If a qualified `vblank` arrives in the same cycle as `irq_ack`, `irq` stays at 1.
- R11: A read of any register offset other than 0x11, 0x12, 0x1A and 0x30 returns 0xFF. This includes the key register. A read with neither window selected also returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Access targets the register window |
| io_sel | input | 1 | Access targets the 1 KB I/O window |
| cpu_we | input | 1 | Write strobe |
| cpu_addr | input | IO_AW | Offset within the selected window |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| raster_line | input | RASTER_W | Current raster line |
| vblank | input | 1 | One-cycle vertical blank pulse |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| ext_mode | output | 1 | 1 = extended mode, 0 = legacy |
| cram_en | output | 1 | Color RAM access enable |
| cram_we | output | 1 | Color RAM write enable |
| cram_addr | output | IO_AW | Color RAM address |
| cram_wdata | output | 8 | Color RAM write data |
| cram_rdata | input | 8 | Color RAM read data |
| per_cs | output | 1 | Peripheral chip-select |
| per_we | output | 1 | Peripheral write enable |
| per_rdata | input | 8 | Peripheral read data |

## Verification
The bench builds the block with RASTER_W = 10 and keeps the default IO_AW of 10. The wider raster line lets one value check both the truncation at offset 0x12 and the upper-bit readback at 0x11. The full 10-bit window offset lets steering be checked at both ends of the 1 KB window. Directed key sequences cover the matching pair, a broken pair, a repeated first key, and a mismatch written while in extended mode.

// File: rtl/vid_regif.sv
module vid_regif #(
  parameter int RASTER_W = 9,
  parameter int IO_AW    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                io_sel,
  input  logic                cpu_we,
  input  logic [IO_AW-1:0]    cpu_addr,
  input  logic [7:0]          cpu_wdata,
  output logic [7:0]          cpu_rdata,
  input  logic [RASTER_W-1:0] raster_line,
  input  logic                vblank,
  input  logic                irq_ack,
  output logic                irq,
  output logic                ext_mode,
  output logic                cram_en,
  output logic                cram_we,
  output logic [IO_AW-1:0]    cram_addr,
  output logic [7:0]          cram_wdata,
  input  logic [7:0]          cram_rdata,
  output logic                per_cs,
  output logic                per_we,
  input  logic [7:0]          per_rdata
);
  localparam int REG_AW = 7;
  localparam logic [REG_AW-1:0] OFS_RAS_HI = 7'h11;
  localparam logic [REG_AW-1:0] OFS_RAS_LO = 7'h12;
  localparam logic [REG_AW-1:0] OFS_MASK   = 7'h1A;
  localparam logic [REG_AW-1:0] OFS_KEY    = 7'h2F;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 7'h30;
  localparam logic [7:0] KEY_A = 8'hA5;
  localparam logic [7:0] KEY_B = 8'h96;

  logic [7:0]        ctrl;
  logic [3:0]        irq_mask;
  logic              key_armed;
  logic [REG_AW-1:0] ofs;
  logic              reg_wr, key_wr, irq_set;
  logic [7:0]        reg_rd, raster_hi;

  assign ofs       = cpu_addr[REG_AW-1:0];
  assign reg_wr    = reg_sel & cpu_we;
  assign key_wr    = reg_wr && ofs == OFS_KEY;
  assign irq_set   = vblank & irq_mask[0];
  assign raster_hi = 8'(raster_line >> 8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      irq_mask  <= '0;
      key_armed <= 1'b0;
      ext_mode  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && ofs == OFS_CTRL) ctrl <= cpu_wdata;
      if (reg_wr && ofs == OFS_MASK) irq_mask <= cpu_wdata[3:0];
      if (key_wr) begin
        ext_mode  <= key_armed && cpu_wdata == KEY_B;
        key_armed <= cpu_wdata == KEY_A;
      end
      if (irq_set)      irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  always_comb begin
    unique case (ofs)
      OFS_RAS_HI: reg_rd = raster_hi;
      OFS_RAS_LO: reg_rd = raster_line[7:0];
      OFS_MASK:   reg_rd = {4'h0, irq_mask};
      OFS_CTRL:   reg_rd = ctrl;
      default:    reg_rd = 8'hFF;
    endcase
  end

  assign cram_en    = io_sel & ctrl[0];
  assign cram_we    = cram_en & cpu_we;
  assign cram_addr  = cpu_addr;
  assign cram_wdata = cpu_wdata;
  assign per_cs     = io_sel & ~ctrl[0];
  assign per_we     = per_cs & cpu_we;

  assign cpu_rdata = reg_sel ? reg_rd :
                     io_sel  ? (ctrl[0] ? cram_rdata : per_rdata) : 8'hFF;

  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && ofs == OFS_CTRL) |=> $stable(ctrl));

  p_mask_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ofs == OFS_MASK) |=> irq_mask == $past(cpu_wdata[3:0]));

  p_ext_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode) |-> $past(key_armed && key_wr && cpu_wdata == KEY_B));

  p_ext_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !(key_armed && cpu_wdata == KEY_B)) |=> !ext_mode);

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(vblank && irq_mask[0]));

  p_irq_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !vblank) |=> !irq);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
endmodule

// File: tb/sim_vid_regif.sv
module sim_vid_regif;
  localparam int RW = 10;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, io_sel = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic [RW-1:0] raster_line = '0;
  logic vblank = 0, irq_ack = 0, irq, ext_mode;
  logic cram_en, cram_we, per_cs, per_we;
  logic [AW-1:0] cram_addr;
  logic [7:0] cram_wdata;
  logic [7:0] cram_rdata = 8'h5A, per_rdata = 8'hC3;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_regif #(.RASTER_W(RW), .IO_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .io_sel(io_sel),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .raster_line(raster_line), .vblank(vblank),
    .irq_ack(irq_ack), .irq(irq), .ext_mode(ext_mode), .cram_en(cram_en),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata),
    .cram_rdata(cram_rdata), .per_cs(per_cs), .per_we(per_we),
    .per_rdata(per_rdata));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle();
    reg_sel = 0; io_sel = 0; cpu_we = 0; vblank = 0; irq_ack = 0;
  endtask

  task automatic wr_reg(logic [6:0] a, logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; cpu_we = 1; cpu_addr = AW'(a); cpu_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_reg(logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; cpu_we = 0; cpu_addr = AW'(a);
    #1 d = cpu_rdata;
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 ext_mode", ext_mode, 0);
    check("R1 irq", irq, 0);
    rd_reg(7'h30, d); check("R1 ctrl", d, 8'h00);
    rd_reg(7'h1A, d); check("R1 mask", d, 8'h00);
    wr_reg(7'h2F, 8'h96);
    check("R1 unarmed after reset", ext_mode, 0);
  endtask

  task automatic t_raster();
    logic [7:0] d;
    raster_line = 10'h3AB;
    rd_reg(7'h12, d); check("R2 low", d, 8'hAB);
    rd_reg(7'h11, d); check("R2 high", d, 8'h03);
    raster_line = 10'h055;
    rd_reg(7'h12, d); check("R2 low b", d, 8'h55);
    rd_reg(7'h11, d); check("R2 high b", d, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr_reg(7'h30, 8'hE6);
    rd_reg(7'h30, d); check("R3 write", d, 8'hE6);
    wr_reg(7'h31, 8'h11);
    wr_reg(7'h1A, 8'h00);
    rd_reg(7'h30, d); check("R3 held", d, 8'hE6);
    wr_reg(7'h30, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr_reg(7'h1A, 8'hFA);
    rd_reg(7'h1A, d); check("R4 low nibble", d, 8'h0A);
    wr_reg(7'h1A, 8'h00);
  endtask

  task automatic t_key();
    wr_reg(7'h2F, 8'hA5);
    check("R5 after first", ext_mode, 0);
    wr_reg(7'h2F, 8'h96);
    check("R5 unlock", ext_mode, 1);
    wr_reg(7'h2F, 8'h00);
    check("R6 other clears", ext_mode, 0);
    wr_reg(7'h2F, 8'hA5);
    wr_reg(7'h2F, 8'h12);
    wr_reg(7'h2F, 8'h96);
    check("R6 broken pair", ext_mode, 0);
    wr_reg(7'h2F, 8'hA5);
    wr_reg(7'h2F, 8'hA5);
    wr_reg(7'h2F, 8'h96);
    check("R6 rearm", ext_mode, 1);
    wr_reg(7'h2F, 8'hA5);
    check("R6 A5 in ext", ext_mode, 0);
    wr_reg(7'h2F, 8'h96);
    check("R6 A5 armed", ext_mode, 1);
    wr_reg(7'h2F, 8'h96);
    check("R6 repeat second", ext_mode, 0);
  endtask

  task automatic t_route_cram();
    wr_reg(7'h30, 8'h01);
    @(negedge clk);
    io_sel = 1; cpu_we = 0; cpu_addr = 10'h3FF;
    #1;
    check("R7 en", cram_en, 1);
    check("R7 no cs", per_cs, 0);
    check("R7 rd", cpu_rdata, 8'h5A);
    check("R7 addr", cram_addr, 10'h3FF);
    check("R7 we idle", cram_we, 0);
    @(negedge clk);
    cpu_we = 1; cpu_addr = 10'h000; cpu_wdata = 8'h7E;
    #1;
    check("R7 we", cram_we, 1);
    check("R7 wdata", cram_wdata, 8'h7E);
    check("R7 addr0", cram_addr, 10'h000);
    check("R7 per_we", per_we, 0);
    idle();
  endtask

  task automatic t_route_per();
    wr_reg(7'h30, 8'hFE);
    @(negedge clk);
    io_sel = 1; cpu_we = 1; cpu_addr = 10'h100;
    #1;
    check("R8 cs", per_cs, 1);
    check("R8 we", per_we, 1);
    check("R8 no cram", cram_en, 0);
    check("R8 no cram we", cram_we, 0);
    check("R8 rd", cpu_rdata, 8'hC3);
    idle();
    wr_reg(7'h30, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); vblank = 1; @(negedge clk); idle();
    check("R9 masked", irq, 0);
    wr_reg(7'h1A, 8'h0E);
    @(negedge clk); vblank = 1; @(negedge clk); idle();
    check("R9 bit0 clear", irq, 0);
    wr_reg(7'h1A, 8'h01);
    @(negedge clk); vblank = 1; @(negedge clk); idle();
    check("R9 raised", irq, 1);
    repeat (3) @(negedge clk);
    check("R10 held", irq, 1);
    vblank = 1; irq_ack = 1; @(negedge clk); idle();
    check("R10 set wins", irq, 1);
    irq_ack = 1; @(negedge clk); idle();
    check("R10 ack", irq, 0);
    wr_reg(7'h1A, 8'h00);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    rd_reg(7'h2F, d); check("R11 key read", d, 8'hFF);
    rd_reg(7'h00, d); check("R11 ofs 00", d, 8'hFF);
    rd_reg(7'h7F, d); check("R11 ofs 7F", d, 8'hFF);
    @(negedge clk); #1;
    check("R11 none selected", cpu_rdata, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_raster();
    t_ctrl();
    t_mask();
    t_key();
    t_route_cram();
    t_route_per();
    t_irq();
    t_unimpl();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule